// File: doc/BRIEF.md
# Data Memory Access Unit with Pointer Redirection

This block is the data-memory front end of a small 8-bit controller core. Each access carries a 7-bit address. The block works out which location that address means: the pointer register it holds, one of fifteen special-function registers that live elsewhere in the core, a general-purpose RAM array it owns, or an unused hole. It then performs a byte read, a byte write, or a single-bit set or clear on that location. Address 00H holds no storage. Any access to it goes to the location named by the lower 7 bits of the pointer register at 01H. When the pointer itself names 00H, a read returns zero and a write does nothing.

The special-function registers are reached only through a one-hot select vector, a write strobe, the merged write value, and an input that carries their current contents. Bit operations are done as a read-modify-write within one cycle. This works the same way on RAM, on the pointer, and on special-function registers. A parameter chooses between the small layout (32 bytes at 60H-7FH) and the large layout (64 bytes at 40H-7FH). A mask parameter marks which special-function registers are read-only.

Top module: `dmem_access_unit`

## Requirements
- R1: A byte write to an address in the general-purpose area (GP_BASE..7FH) is stored on the clock edge. A later read of that address returns it, with the read data valid in the same cycle as the read strobe.
- R2: Address 00H resolves to the location whose address is the pointer register's bits 6:0. Reads, byte writes and bit operations all go to that location.
- R3: The pointer register at 01H holds all 8 bits, reads back the full byte, and changes only when a write or bit operation resolves to 01H.
- R4: When address 00H is used and the pointer's bits 6:0 are zero, a read returns 00H and a write or bit operation changes no storage.
- R5: Every address that is not 01H, not a special-function register and not in the general-purpose area reads as 00H and discards writes. With LARGE_RAM=0 this includes 40H-5FH.
- R6: During an access (any strobe high), sfr_sel is one-hot for the resolved special-function address. Bit i maps to address 05H,06H,07H,08H,09H,0AH,0BH,0DH,0EH,12H,13H,14H,15H,16H,17H for i = 0..14. sfr_sel is all zero when no strobe is high.
- R7: A read that resolves to a special-function register returns the value on sfr_rdata.
- R8: A bit set (clear) writes the current value with bit bit_idx forced to 1 (0) in the same cycle. For a special-function register the merged byte appears on sfr_wdata with sfr_wr high.
- R9: A special-function register whose bit is set in SFR_RO_MASK never gets sfr_wr, whether the access is a byte write or a bit operation. The default mask marks select bit 3 (08H).
- R10: When several write strobes are high together, the byte write takes priority over bit clear, and bit clear takes priority over bit set.
- R11: rd_data is 00H whenever rd_en is low.
- R12: Reset clears the pointer register and every general-purpose RAM byte to 00H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 7 | Data address of the access |
| wr_data | input | 8 | Byte write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Byte write strobe |
| bit_set | input | 1 | Single-bit set strobe |
| bit_clr | input | 1 | Single-bit clear strobe |
| bit_idx | input | 3 | Bit number for set/clear |
| sfr_rdata | input | 8 | Current contents of the selected special-function register |
| rd_data | output | 8 | Read result |
| sfr_sel | output | 15 | One-hot special-function register select |
| sfr_wr | output | 1 | Write strobe to the selected special-function register |
| sfr_wdata | output | 8 | Byte to write into the selected special-function register |

## Verification
The bench builds the block with LARGE_RAM=0 and the default read-only mask. In the small layout, 40H-5FH is an unused hole, so the same run checks both ends of the RAM and the reserved range just below it. With the default mask, the bench can show that byte writes and bit operations to 08H are blocked while the neighbouring writable registers still receive sfr_wr. Pointer values of 00H, 7FH, 12H and E0H cover the self-reference case, the top of RAM, a special-function target, and the dropped pointer bit 7.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
   localparam int ADDR_W  = 7;
   localparam int DATA_W  = 8;
   localparam int NUM_SFR = 15;
   localparam logic [ADDR_W-1:0] PTR_ADDR = 7'h01;

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_PTR  = 2'd1,
      RGN_SFR  = 2'd2,
      RGN_RAM  = 2'd3
   } region_e;

   // Address of special-function select bit idx (three contiguous runs).
   function automatic logic [ADDR_W-1:0] sfr_addr(input int idx);
      int a;
      if (idx < 7)      a = 5 + idx;
      else if (idx < 9) a = 13 + (idx - 7);
      else              a = 18 + (idx - 9);
      return ADDR_W'(a);
   endfunction
endpackage

// File: rtl/dmem_addr_resolve.sv
module dmem_addr_resolve
   import dmem_pkg::*;
(
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] ptr_q,
   output logic [ADDR_W-1:0] eff_addr,
   output logic              self_ref
);
   logic is_virtual;

   always_comb begin
      is_virtual = (addr == '0);
      eff_addr   = is_virtual ? ptr_q[ADDR_W-1:0] : addr;
      self_ref   = is_virtual && (ptr_q[ADDR_W-1:0] == '0);
   end
endmodule

// File: rtl/dmem_region_decode.sv
module dmem_region_decode
   import dmem_pkg::*;
#(
   parameter int GP_BASE = 64,
   parameter int GP_AW   = 6
)(
   input  logic [ADDR_W-1:0]  eff_addr,
   output region_e            region,
   output logic [NUM_SFR-1:0] sfr_hit,
   output logic [GP_AW-1:0]   gp_idx
);
   logic [ADDR_W-1:0] gp_off;

   for (genvar i = 0; i < NUM_SFR; i++) begin : g_sfr_cmp
      assign sfr_hit[i] = (eff_addr == sfr_addr(i));
   end

   always_comb begin
      gp_off = eff_addr - ADDR_W'(GP_BASE);
      gp_idx = gp_off[GP_AW-1:0];
      if (eff_addr == PTR_ADDR)                   region = RGN_PTR;
      else if (|sfr_hit)                          region = RGN_SFR;
      else if (32'(eff_addr) >= GP_BASE)          region = RGN_RAM;
      else                                        region = RGN_NONE;
   end
endmodule

// File: rtl/dmem_gp_ram.sv
module dmem_gp_ram #(
   parameter int DEPTH = 64,
   parameter int AW    = 6,
   parameter int DW    = 8
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] idx,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem_q [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem_q[w] <= '0;
         else if (we && (32'(idx) == w))
            mem_q[w] <= wdata;
      end
   end

   assign rdata = mem_q[idx];
endmodule

// File: rtl/dmem_access_unit.sv
module dmem_access_unit
   import dmem_pkg::*;
#(
   parameter bit                 LARGE_RAM   = 1'b1,
   parameter logic [NUM_SFR-1:0] SFR_RO_MASK = 15'h0008
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [6:0]         addr,
   input  logic [7:0]         wr_data,
   input  logic               rd_en,
   input  logic               wr_en,
   input  logic               bit_set,
   input  logic               bit_clr,
   input  logic [2:0]         bit_idx,
   input  logic [7:0]         sfr_rdata,
   output logic [7:0]         rd_data,
   output logic [14:0]        sfr_sel,
   output logic               sfr_wr,
   output logic [7:0]         sfr_wdata
);
   localparam int GP_DEPTH = LARGE_RAM ? 64 : 32;
   localparam int GP_BASE  = (1 << ADDR_W) - GP_DEPTH;
   localparam int GP_AW    = $clog2(GP_DEPTH);

   if (GP_BASE <= 32'(sfr_addr(NUM_SFR-1))) begin : g_bad_layout
      $error("general-purpose area overlaps special-function space");
   end

   logic [DATA_W-1:0]  ptr_q;
   logic [ADDR_W-1:0]  eff_addr;
   logic               self_ref;
   region_e            region;
   logic [NUM_SFR-1:0] sfr_hit;
   logic [GP_AW-1:0]   gp_idx;
   logic [DATA_W-1:0]  ram_rd;
   logic [DATA_W-1:0]  cur_val, new_val, bit_mask;
   logic               any_strobe, mod_req, ro_hit, wr_ok;

   dmem_addr_resolve u_resolve (
      .addr     (addr),
      .ptr_q    (ptr_q),
      .eff_addr (eff_addr),
      .self_ref (self_ref)
   );

   dmem_region_decode #(.GP_BASE(GP_BASE), .GP_AW(GP_AW)) u_decode (
      .eff_addr (eff_addr),
      .region   (region),
      .sfr_hit  (sfr_hit),
      .gp_idx   (gp_idx)
   );

   always_comb begin
      any_strobe = rd_en | wr_en | bit_set | bit_clr;
      mod_req    = wr_en | bit_set | bit_clr;
      bit_mask   = DATA_W'(1) << bit_idx;
      ro_hit     = |(sfr_hit & SFR_RO_MASK);
      unique case (region)
         RGN_PTR: cur_val = ptr_q;
         RGN_SFR: cur_val = sfr_rdata;
         RGN_RAM: cur_val = ram_rd;
         default: cur_val = '0;
      endcase
      // Byte write over clear over set.
      if (wr_en)        new_val = wr_data;
      else if (bit_clr) new_val = cur_val & ~bit_mask;
      else              new_val = cur_val | bit_mask;
      wr_ok     = mod_req && !self_ref && (region != RGN_NONE) && !ro_hit;
      rd_data   = rd_en ? cur_val : '0;
      sfr_sel   = any_strobe ? sfr_hit : '0;
      sfr_wr    = wr_ok && (region == RGN_SFR);
      sfr_wdata = sfr_wr ? new_val : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (wr_ok && (region == RGN_PTR))
         ptr_q <= new_val;
   end

   dmem_gp_ram #(.DEPTH(GP_DEPTH), .AW(GP_AW), .DW(DATA_W)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_ok && (region == RGN_RAM)),
      .idx   (gp_idx),
      .wdata (new_val),
      .rdata (ram_rd)
   );
endmodule

// File: rtl/dmem_access_unit_chk.sv
module dmem_access_unit_chk #(
   parameter logic [14:0] RO_MASK = 15'h0008
)(
   input logic        clk,
   input logic        rst_n,
   input logic [6:0]  addr,
   input logic        rd_en,
   input logic        wr_en,
   input logic        bit_set,
   input logic        bit_clr,
   input logic [7:0]  rd_data,
   input logic [14:0] sfr_sel,
   input logic        sfr_wr,
   input logic [7:0]  ptr_q
);
   p_sel_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sfr_sel));

   p_sel_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en | wr_en | bit_set | bit_clr) |-> (sfr_sel == '0));

   p_ro_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((sfr_sel & RO_MASK) != '0) |-> !sfr_wr);

   p_idle_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rd_data == 8'h00));

   p_self_ref_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == 7'h00 && ptr_q[6:0] == 7'h00) |-> (rd_data == 8'h00));

   p_self_ref_no_sfr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == 7'h00 && ptr_q[6:0] == 7'h00) |-> !sfr_wr);

   p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en | bit_set | bit_clr) |=> $stable(ptr_q));
endmodule

bind dmem_access_unit dmem_access_unit_chk #(.RO_MASK(SFR_RO_MASK)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .addr    (addr),
   .rd_en   (rd_en),
   .wr_en   (wr_en),
   .bit_set (bit_set),
   .bit_clr (bit_clr),
   .rd_data (rd_data),
   .sfr_sel (sfr_sel),
   .sfr_wr  (sfr_wr),
   .ptr_q   (ptr_q)
);

// File: tb/dmem_access_unit_tb_top.sv
module dmem_access_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  addr = '0;
   logic [7:0]  wr_data = '0;
   logic        rd_en = 1'b0, wr_en = 1'b0, bit_set = 1'b0, bit_clr = 1'b0;
   logic [2:0]  bit_idx = '0;
   logic [7:0]  sfr_rdata = 8'h3C;
   logic [7:0]  rd_data;
   logic [14:0] sfr_sel;
   logic        sfr_wr;
   logic [7:0]  sfr_wdata;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   dmem_access_unit #(.LARGE_RAM(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
      .rd_en(rd_en), .wr_en(wr_en), .bit_set(bit_set), .bit_clr(bit_clr),
      .bit_idx(bit_idx), .sfr_rdata(sfr_rdata), .rd_data(rd_data),
      .sfr_sel(sfr_sel), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata)
   );

   localparam logic [1:0] OP_R = 2'd0, OP_W = 2'd1, OP_S = 2'd2, OP_C = 2'd3;
   // {req[3:0], op[1:0], addr[6:0], data[7:0], bit[2:0], expected read[7:0]}
   localparam int NV = 27;
   localparam logic [31:0] VEC [NV] = '{
      {4'd1,  OP_W, 7'h60, 8'hAA, 3'd0, 8'h00},  // R1
      {4'd1,  OP_R, 7'h60, 8'h00, 3'd0, 8'hAA},  // R1 bottom of RAM
      {4'd1,  OP_W, 7'h7F, 8'h55, 3'd0, 8'h00},
      {4'd1,  OP_R, 7'h7F, 8'h00, 3'd0, 8'h55},  // R1 top of RAM
      {4'd3,  OP_W, 7'h01, 8'h7F, 3'd0, 8'h00},
      {4'd2,  OP_R, 7'h00, 8'h00, 3'd0, 8'h55},  // R2 indirect read
      {4'd2,  OP_W, 7'h00, 8'h11, 3'd0, 8'h00},
      {4'd2,  OP_R, 7'h7F, 8'h00, 3'd0, 8'h11},  // R2 indirect write
      {4'd8,  OP_S, 7'h00, 8'h00, 3'd7, 8'h00},
      {4'd8,  OP_R, 7'h7F, 8'h00, 3'd0, 8'h91},  // R8 indirect set
      {4'd8,  OP_C, 7'h7F, 8'h00, 3'd0, 8'h00},
      {4'd8,  OP_R, 7'h00, 8'h00, 3'd0, 8'h90},  // R8 clear
      {4'd5,  OP_W, 7'h40, 8'hEE, 3'd0, 8'h00},
      {4'd5,  OP_R, 7'h40, 8'h00, 3'd0, 8'h00},  // R5 hole below RAM
      {4'd3,  OP_W, 7'h01, 8'h00, 3'd0, 8'h00},
      {4'd4,  OP_R, 7'h00, 8'h00, 3'd0, 8'h00},  // R4 self-reference read
      {4'd4,  OP_W, 7'h00, 8'h77, 3'd0, 8'h00},
      {4'd4,  OP_R, 7'h01, 8'h00, 3'd0, 8'h00},  // R4 write dropped
      {4'd5,  OP_R, 7'h02, 8'h00, 3'd0, 8'h00},  // R5 reserved
      {4'd3,  OP_W, 7'h01, 8'hE0, 3'd0, 8'h00},
      {4'd3,  OP_R, 7'h01, 8'h00, 3'd0, 8'hE0},  // R3 full byte
      {4'd2,  OP_R, 7'h00, 8'h00, 3'd0, 8'hAA},  // R2 bit 7 ignored
      {4'd8,  OP_S, 7'h01, 8'h00, 3'd0, 8'h00},
      {4'd3,  OP_R, 7'h01, 8'h00, 3'd0, 8'hE1},  // R3 bit op on pointer
      {4'd12, OP_R, 7'h00, 8'h00, 3'd0, 8'h00},  // R12 61H still reset
      {4'd7,  OP_R, 7'h05, 8'h00, 3'd0, 8'h3C},  // R7
      {4'd5,  OP_R, 7'h5F, 8'h00, 3'd0, 8'h00}   // R5 last hole byte
   };

   task automatic drive(input logic [1:0] op, input logic [6:0] a,
                        input logic [7:0] d, input logic [2:0] b);
      @(negedge clk);
      addr = a; wr_data = d; bit_idx = b;
      rd_en = (op == OP_R); wr_en = (op == OP_W);
      bit_set = (op == OP_S); bit_clr = (op == OP_C);
      #2;
   endtask

   task automatic multi(input logic w, input logic s, input logic c,
                        input logic [6:0] a, input logic [7:0] d, input logic [2:0] b);
      @(negedge clk);
      addr = a; wr_data = d; bit_idx = b;
      rd_en = 1'b0; wr_en = w; bit_set = s; bit_clr = c;
      #2;
   endtask

   task automatic idle();
      @(negedge clk);
      rd_en = 0; wr_en = 0; bit_set = 0; bit_clr = 0;
      #2;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // Reset state
      idle();
      chk("R11 idle rd_data", 32'(rd_data), 32'h00);
      chk("R6 idle sfr_sel", 32'(sfr_sel), 32'h0);
      drive(OP_R, 7'h01, 8'h00, 3'd0);
      chk("R12 pointer reset", 32'(rd_data), 32'h00);
      drive(OP_R, 7'h60, 8'h00, 3'd0);
      chk("R12 RAM reset", 32'(rd_data), 32'h00);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][27:26], VEC[i][25:19], VEC[i][18:11], VEC[i][10:8]);
         if (VEC[i][27:26] == OP_R)
            chk($sformatf("R%0d vector %0d", VEC[i][31:28], i), 32'(rd_data), 32'(VEC[i][7:0]));
      end

      // R6 select encoding, direct and through the pointer
      drive(OP_R, 7'h05, 8'h00, 3'd0);
      chk("R6 sel 05H", 32'(sfr_sel), 32'h0001);
      drive(OP_R, 7'h17, 8'h00, 3'd0);
      chk("R6 sel 17H", 32'(sfr_sel), 32'h4000);
      drive(OP_W, 7'h01, 8'h12, 3'd0);
      drive(OP_R, 7'h00, 8'h00, 3'd0);
      chk("R2 R6 indirect sel 12H", 32'(sfr_sel), 32'h0200);
      idle();
      chk("R6 no strobe", 32'(sfr_sel), 32'h0);

      // SFR writes
      drive(OP_W, 7'h06, 8'h5A, 3'd0);
      chk("R6 sfr_wr 06H", 32'(sfr_wr), 32'h1);
      chk("R6 sfr_wdata 06H", 32'(sfr_wdata), 32'h5A);
      drive(OP_W, 7'h08, 8'h5A, 3'd0);
      chk("R9 byte write to read-only", 32'(sfr_wr), 32'h0);
      drive(OP_S, 7'h08, 8'h00, 3'd1);
      chk("R9 bit set to read-only", 32'(sfr_wr), 32'h0);
      drive(OP_S, 7'h0A, 8'h00, 3'd0);
      chk("R8 sfr set strobe", 32'(sfr_wr), 32'h1);
      chk("R8 sfr set data", 32'(sfr_wdata), 32'h3D);
      drive(OP_C, 7'h0A, 8'h00, 3'd2);
      chk("R8 sfr clear data", 32'(sfr_wdata), 32'h38);

      // R10 priority
      multi(1'b1, 1'b1, 1'b1, 7'h62, 8'h0F, 3'd7);
      drive(OP_R, 7'h62, 8'h00, 3'd0);
      chk("R10 byte write wins", 32'(rd_data), 32'h0F);
      multi(1'b0, 1'b1, 1'b1, 7'h62, 8'h00, 3'd0);
      drive(OP_R, 7'h62, 8'h00, 3'd0);
      chk("R10 clear over set", 32'(rd_data), 32'h0E);

      idle();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule